// File: doc/BRIEF.md
# UART Receive Status Flags

This block sits between a UART receive shifter and the CPU-facing register file. It holds the last received character and keeps three sticky receive flags: receive-full, line-idle and overrun. Bit sampling and baud generation happen elsewhere. The shifter signals each finished character with a one-cycle strobe, and a bit-rate tick carries the sampled line level. The CPU sees an eight-bit status byte and the data register.

A flag is cleared only by a two-step sequence. First a status read must see the flag set. Then a later data read clears it. An overrun that lands between those two reads therefore survives the data read. Idle detection counts consecutive logic-1 bit times. It is armed only by a character that really loads the data register, and each arming yields at most one idle flag. Two interrupt requests are formed from the flags and their enables. The noise, framing, parity and transmitter bits are passed straight into the status byte.

Top module: `rx_status_flags`

## Requirements
- R1: After reset, status bits 5..3 are 0, the data register is 0, and both interrupt requests are 0.
- R2: A character strobe with receive-full clear and the receiver enabled loads the data register with the character. It also sets receive-full (status bit 5). Both are visible after the clock edge that samples the strobe.
- R3: A character strobe while receive-full is set does three things: it sets overrun (status bit 3), it discards the character, and it leaves the data register unchanged.
- R4: A status read that sees a flag set, followed by a data read in a later cycle, clears that flag after the edge that samples the data read.
- R5: A data read that was not preceded by a status read seeing the flag set leaves that flag set.
- R6: Overrun set after the status read and before the data read stays set through that data read. Receive-full still clears.
- R7: Once armed, the idle flag (status bit 4) sets on the IDLE_LEN-th consecutive bit tick with the line at 1. A tick with the line at 0, or any character strobe, restarts the count.
- R8: The idle flag cannot set until a character has set receive-full since the receiver was enabled. After the flag is cleared, it cannot set again until a new character has set receive-full.
- R9: While the receiver enable is low, character strobes are ignored: no flag changes and the data register is unchanged.
- R10: The status byte from bit 7 down to bit 0 is: transmit-empty input, transmit-complete input, receive-full, idle, overrun, noise input, framing-error input, parity-error input. With both transmitter inputs high and the error inputs low, the reset value is 8'b11000000.
- R11: rx_irq equals receive-full AND rx_ie. err_irq equals (idle AND idle_ie) OR (overrun AND ovr_ie).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| char_done | input | 1 | One-cycle strobe: shifter finished a character |
| char_data | input | DATA_W | Character from the shifter |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| line_bit | input | 1 | Sampled serial line level, valid with bit_tick |
| stat_rd | input | 1 | CPU status byte read strobe |
| data_rd | input | 1 | CPU data register read strobe |
| rx_ie | input | 1 | Receive-full interrupt enable |
| idle_ie | input | 1 | Idle interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| tx_empty_in | input | 1 | Transmitter-empty bit from the transmit side |
| tx_done_in | input | 1 | Transmit-complete bit from the transmit side |
| noise_in | input | 1 | Noise bit from the sampler |
| frame_err_in | input | 1 | Framing error bit from the sampler |
| parity_err_in | input | 1 | Parity error bit from the sampler |
| data_out | output | DATA_W | Held received character |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every flag and the data register are registered once. A strobe, read or tick driven in one cycle shows up at the ports after exactly one rising edge. The passthrough bits and both interrupt requests are combinational from those registers and the inputs. The bench drives each stimulus just after a falling edge, holds it for one full cycle, and samples at the next falling edge, so each check lands on the first cycle the result is due. Idle run lengths are swept from one tick to one past the threshold, so the flag is checked on both sides of the exact tick where it must rise.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

    // Bit positions inside the status byte; the CPU decodes these.
    localparam int unsigned ST_TX_EMPTY = 7;
    localparam int unsigned ST_TX_DONE  = 6;
    localparam int unsigned ST_FULL     = 5;
    localparam int unsigned ST_IDLE     = 4;
    localparam int unsigned ST_OVR      = 3;
    localparam int unsigned ST_NOISE    = 2;
    localparam int unsigned ST_FRAME    = 1;
    localparam int unsigned ST_PARITY   = 0;
    localparam int unsigned ST_W        = 8;

    typedef struct packed {
        logic full;
        logic idle;
        logic ovr;
    } rx_flags_t;

endpackage

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
    parameter int unsigned IDLE_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic bit_tick,
    input  logic line_bit,
    input  logic char_seen,
    input  logic char_valid,
    output logic idle_hit
);
    localparam int unsigned CW = $clog2(IDLE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_LEN - 1);
    localparam logic [CW-1:0] SAT  = CW'(IDLE_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } idle_st_t;

    idle_st_t s_d, s_q;
    logic     hit;

    always_comb begin
        hit = rx_en && s_q.armed && bit_tick && line_bit && !char_seen
              && (s_q.cnt == LAST);
        s_d = s_q;
        if (!rx_en) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
        end else begin
            if (char_seen) begin
                s_d.cnt = '0;
            end else if (bit_tick) begin
                if (!line_bit) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt != SAT) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (char_valid) begin
                s_d.armed = 1'b1;
            end else if (hit) begin
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_hit = hit;

endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
    import rx_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      char_ok,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  logic      idle_hit,
    output logic      load,
    output rx_flags_t flags
);
    typedef struct packed {
        rx_flags_t flag;
        rx_flags_t seen;
    } fl_st_t;

    fl_st_t    s_d, s_q;
    rx_flags_t clr;
    logic      set_full;
    logic      set_ovr;

    always_comb begin
        set_full = char_ok && !s_q.flag.full;
        set_ovr  = char_ok &&  s_q.flag.full;
        clr.full = data_rd && s_q.seen.full;
        clr.idle = data_rd && s_q.seen.idle;
        clr.ovr  = data_rd && s_q.seen.ovr;

        s_d = s_q;
        s_d.flag.full = set_full || (s_q.flag.full && !clr.full);
        s_d.flag.ovr  = set_ovr  || (s_q.flag.ovr  && !clr.ovr);
        s_d.flag.idle = idle_hit || (s_q.flag.idle && !clr.idle);

        if (stat_rd) begin
            s_d.seen = s_q.flag;
        end else if (data_rd) begin
            s_d.seen = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load  = set_full;
    assign flags = s_q.flag;

endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign dout = data_q;

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
    import rx_status_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDLE_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              bit_tick,
    input  logic              line_bit,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_ie,
    input  logic              idle_ie,
    input  logic              ovr_ie,
    input  logic              tx_empty_in,
    input  logic              tx_done_in,
    input  logic              noise_in,
    input  logic              frame_err_in,
    input  logic              parity_err_in,
    output logic [DATA_W-1:0] data_out,
    output logic [ST_W-1:0]   status,
    output logic              rx_irq,
    output logic              err_irq
);
    logic      char_ok;
    logic      load;
    logic      idle_hit;
    rx_flags_t flags;

    assign char_ok = char_done && rx_en;

    rx_idle_detect #(.IDLE_LEN(IDLE_LEN)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .bit_tick   (bit_tick),
        .line_bit   (line_bit),
        .char_seen  (char_ok),
        .char_valid (load),
        .idle_hit   (idle_hit)
    );

    rx_flag_ctrl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_ok  (char_ok),
        .stat_rd  (stat_rd),
        .data_rd  (data_rd),
        .idle_hit (idle_hit),
        .load     (load),
        .flags    (flags)
    );

    rx_data_hold #(.DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (char_data),
        .dout  (data_out)
    );

    always_comb begin
        status              = '0;
        status[ST_TX_EMPTY] = tx_empty_in;
        status[ST_TX_DONE]  = tx_done_in;
        status[ST_FULL]     = flags.full;
        status[ST_IDLE]     = flags.idle;
        status[ST_OVR]      = flags.ovr;
        status[ST_NOISE]    = noise_in;
        status[ST_FRAME]    = frame_err_in;
        status[ST_PARITY]   = parity_err_in;
        rx_irq  = flags.full && rx_ie;
        err_irq = (flags.idle && idle_ie) || (flags.ovr && ovr_ie);
    end

endmodule

// File: rtl/rx_status_chk.sv
module rx_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              char_done,
    input logic [DATA_W-1:0] char_data,
    input logic              bit_tick,
    input logic              line_bit,
    input logic              data_rd,
    input logic [DATA_W-1:0] data_out,
    input logic [7:0]        status
);
    // R2
    load_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_en && !status[5]) |=> (status[5] && data_out == $past(char_data)));

    // R3
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && rx_en && status[5]) |=> (status[3] && $stable(data_out)));

    // R4
    full_falls_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[5]) |-> $past(data_rd));

    // R6
    ovr_falls_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[3]) |-> $past(data_rd));

    // R7
    idle_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(bit_tick && line_bit));

    // R9
    disabled_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !status[5]) |=> !status[5]);

endmodule

bind rx_status_flags rx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .char_done (char_done),
    .char_data (char_data),
    .bit_tick  (bit_tick),
    .line_bit  (line_bit),
    .data_rd   (data_rd),
    .data_out  (data_out),
    .status    (status)
);

// File: tb/tb_rx_status_flags.sv
`timescale 1ns/1ps
module tb_rx_status_flags;
    localparam int DATA_W   = 8;
    localparam int IDLE_LEN = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, char_done = 1'b0, bit_tick = 1'b0, line_bit = 1'b1;
    logic stat_rd = 1'b0, data_rd = 1'b0;
    logic rx_ie = 1'b0, idle_ie = 1'b0, ovr_ie = 1'b0;
    logic tx_empty_in = 1'b1, tx_done_in = 1'b1;
    logic noise_in = 1'b0, frame_err_in = 1'b0, parity_err_in = 1'b0;
    logic [DATA_W-1:0] char_data = '0;
    logic [DATA_W-1:0] data_out;
    logic [7:0] status;
    logic rx_irq, err_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_status_flags #(.DATA_W(DATA_W), .IDLE_LEN(IDLE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_done(char_done),
        .char_data(char_data), .bit_tick(bit_tick), .line_bit(line_bit),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_ie(rx_ie), .idle_ie(idle_ie),
        .ovr_ie(ovr_ie), .tx_empty_in(tx_empty_in), .tx_done_in(tx_done_in),
        .noise_in(noise_in), .frame_err_in(frame_err_in),
        .parity_err_in(parity_err_in), .data_out(data_out), .status(status),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_char(input logic [DATA_W-1:0] d);
        char_done = 1'b1; char_data = d;
        @(negedge clk);
        char_done = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic rd_data();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic ticks(input int n, input logic b);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; line_bit = b;
            @(negedge clk);
            bit_tick = 1'b0; line_bit = 1'b1;
        end
    endtask

    task automatic clear_all();
        rd_stat();
        rd_data();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10 reset state
        check("R1 flags", 32'(status[5:3]), 32'd0);
        check("R1 data", 32'(data_out), 32'd0);
        check("R1 irqs", {30'd0, rx_irq, err_irq}, 32'd0);
        check("R10 reset byte", 32'(status), 32'hC0);

        // R10 passthrough sweep
        for (int v = 0; v < 32; v++) begin
            {tx_empty_in, tx_done_in, noise_in, frame_err_in, parity_err_in} = 5'(v);
            #1;
            check("R10 layout", 32'(status),
                  32'(((v >> 4) & 1) << 7 | ((v >> 3) & 1) << 6 | (v & 7)));
        end
        {tx_empty_in, tx_done_in, noise_in, frame_err_in, parity_err_in} = 5'b11000;
        @(negedge clk);

        // R9 ignored while disabled
        pulse_char(8'hAA);
        check("R9 full", 32'(status[5]), 32'd0);
        check("R9 data", 32'(data_out), 32'd0);

        // R8 not armed before first character
        rx_en = 1'b1;
        @(negedge clk);
        ticks(IDLE_LEN + 3, 1'b1);
        check("R8 unarmed idle", 32'(status[4]), 32'd0);

        // R2 / R4 / R5 data sweep
        for (int i = 0; i < 16; i++) begin
            logic [DATA_W-1:0] d;
            d = DATA_W'(i * 17) ^ 8'h5A;
            pulse_char(d);
            check("R2 data", 32'(data_out), 32'(d));
            check("R2 full", 32'(status[5]), 32'd1);
            if (i == 0) begin
                rd_data();
                check("R5 full kept", 32'(status[5]), 32'd1);
            end
            clear_all();
            check("R4 full clear", 32'(status[5]), 32'd0);
        end

        // R7 run-length sweep
        for (int n = 1; n <= IDLE_LEN + 1; n++) begin
            pulse_char(DATA_W'(n));
            clear_all();
            ticks(n, 1'b1);
            check("R7 idle run", 32'(status[4]), 32'(n >= IDLE_LEN));
            if (n >= IDLE_LEN) begin
                clear_all();
                check("R4 idle clear", 32'(status[4]), 32'd0);
            end
        end

        // R7 zero restarts the count
        pulse_char(8'h01);
        clear_all();
        ticks(IDLE_LEN - 1, 1'b1);
        ticks(1, 1'b0);
        ticks(IDLE_LEN - 1, 1'b1);
        check("R7 restart", 32'(status[4]), 32'd0);
        ticks(1, 1'b1);
        check("R7 after restart", 32'(status[4]), 32'd1);

        // R8 re-arm only by a new character
        clear_all();
        check("R8 cleared", 32'(status[4]), 32'd0);
        ticks(IDLE_LEN + 2, 1'b1);
        check("R8 no rearm", 32'(status[4]), 32'd0);
        pulse_char(8'h02);
        clear_all();
        ticks(IDLE_LEN, 1'b1);
        check("R8 rearmed", 32'(status[4]), 32'd1);
        clear_all();

        // R3 overrun keeps old data, R4 clears it
        pulse_char(8'h11);
        pulse_char(8'h22);
        check("R3 ovr", 32'(status[3]), 32'd1);
        check("R3 data", 32'(data_out), 32'h11);
        clear_all();
        check("R4 ovr clear", 32'(status[5:3]), 32'd0);

        // R6 overrun between status and data read
        pulse_char(8'h33);
        rd_stat();
        pulse_char(8'h44);
        rd_data();
        check("R6 full clear", 32'(status[5]), 32'd0);
        check("R6 ovr kept", 32'(status[3]), 32'd1);
        check("R6 data", 32'(data_out), 32'h33);
        clear_all();
        check("R6 ovr later clear", 32'(status[3]), 32'd0);

        // R11 interrupt enable sweep
        pulse_char(8'h01);
        pulse_char(8'h02);
        ticks(IDLE_LEN, 1'b1);
        check("R11 setup", 32'(status[5:3]), 32'd7);
        for (int e = 0; e < 8; e++) begin
            {ovr_ie, idle_ie, rx_ie} = 3'(e);
            #1;
            check("R11 rx", 32'(rx_irq), 32'(e & 1));
            check("R11 err", 32'(err_irq), 32'((e >> 1) != 0));
        end
        clear_all();
        for (int e = 0; e < 8; e++) begin
            {ovr_ie, idle_ie, rx_ie} = 3'(e);
            #1;
            check("R11 quiet", {30'd0, rx_irq, err_irq}, 32'd0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule